// File: doc/BRIEF.md
# Quad PWM Generator with Pair Concatenation

This block produces four pulse-width modulated waveforms from four 8-bit counter channels. Each channel counts ticks of one of three externally supplied clock-enable strobes (A, B and S), restarts at a programmable period and flips its pin at a programmable duty count. The level at the start of each period is set per channel. Period and duty values are written to holding registers. These values reach the running channel only at a period boundary, or at once when software writes the channel's counter.

Channels 0/1 and channels 2/3 can be joined into one 16-bit channel. The even channel holds the low byte and the odd channel holds the high byte. In a joined pair, the even channel's enable, polarity and strobe select control the pair. Its pin carries the waveform and the odd pin stays low. A simple synchronous write port and a combinational read port give access to all registers. Each pin is registered, so it follows the counter state with one clock of delay.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads 0 and all four pins are low.
- R2: Register map, 4-bit address, 8-bit data. Address 0 is enable, 1 is polarity and 2 is strobe select; bit n of each belongs to channel n. Address 3 is pair config: bit0 joins 0/1, bit1 joins 2/3, bit2 makes pair 0 use S in place of B, bit3 does the same for pair 1. Addresses 4+n, 8+n and 12+n are counter n, period n and duty n. Control registers keep only bits 3:0. Period and duty reads return the holding register.
- R3: While enabled, the counter goes up by one on each tick of its strobe. A tick taken while the counter equals the active period returns it to 0, so one period lasts period+1 ticks. A counter read returns its current value.
- R4: While enabled, the pin is at the polarity bit's level (1 = high) while the counter is below the active duty, and at the opposite level otherwise. So duty 0 gives a constant opposite level, and duty above period gives a constant polarity level.
- R5: A disabled channel holds its counter at 0 and drives its pin low.
- R6: Writing period or duty leaves the active values unchanged until the next wrap, where both holding registers are copied in.
- R7: Any write to a counter address clears that counter and copies the holding registers into the active registers in the same cycle.
- R8: A select bit of 0 picks strobe A. A select bit of 1 picks strobe B, or strobe S when the pair's S bit is set.
- R9: A joined pair behaves as one 16-bit channel under R3 to R7, with the odd channel as high byte, using the even channel's controls. Its waveform appears on the even pin, the odd pin stays low, and a write to either counter address clears both bytes.
- R10: Joining or splitting a pair clears both of its counters and reloads their active registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| stb_a | input | 1 | Clock-enable strobe A |
| stb_b | input | 1 | Clock-enable strobe B |
| stb_s | input | 1 | Clock-enable strobe S |
| pwm_out | output | 4 | Waveform pins, bit n for channel n |

## Verification
The assertions check four things on every cycle: a disabled pin stays low, the odd pin of a joined pair stays low, a counter write leaves a zero counter, and a counter never exceeds its active period in either width mode. The bench scenarios cover what needs a known history. These are the high time over a full period for each polarity and for the duty edge cases, the held and forced reloads, strobe routing, and the 16-bit carry and waveform.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the register-group encoding of the quad PWM.
// Assumes four channels organised as two pairs and a 4-bit register address.
package pwm_quad_pkg;
    localparam int NCH   = 4;
    localparam int NPAIR = NCH / 2;
    localparam int AW    = 4;

    // Upper two address bits select a register group.
    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_CNT  = 2'd1,
        GRP_PER  = 2'd2,
        GRP_DUTY = 2'd3
    } grp_e;

    // Lower two address bits inside the control group.
    localparam logic [1:0] CTRL_EN  = 2'd0;
    localparam logic [1:0] CTRL_POL = 2'd1;
    localparam logic [1:0] CTRL_SEL = 2'd2;
    localparam logic [1:0] CTRL_CFG = 2'd3;
endpackage

// File: rtl/pwm_quad_regs.sv
`timescale 1ns/1ps
// Register file: holds the control bits and the period/duty holding registers.
// Decodes counter writes into one-cycle clear pulses and serves reads.
// Assumes CW >= NCH so the control bits fit in one data word.
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [CW-1:0]            bus_wdata,
    output logic [CW-1:0]            bus_rdata,
    input  logic [NCH-1:0][CW-1:0]   cnt_in,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           pol_o,
    output logic [NCH-1:0]           sel_o,
    output logic [NCH-1:0]           cfg_o,
    output logic [NCH-1:0][CW-1:0]   per_buf_o,
    output logic [NCH-1:0][CW-1:0]   duty_buf_o,
    output logic [NCH-1:0]           cnt_wr_o
);
    grp_e       grp;
    logic [1:0] idx;

    assign grp = grp_e'(bus_addr[3:2]);
    assign idx = bus_addr[1:0];

    // Register writes: control bits and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= '0;
            pol_o      <= '0;
            sel_o      <= '0;
            cfg_o      <= '0;
            per_buf_o  <= '0;
            duty_buf_o <= '0;
        end else if (bus_wr) begin
            case (grp)
                GRP_CTRL: begin
                    case (idx)
                        CTRL_EN:  en_o  <= bus_wdata[NCH-1:0];
                        CTRL_POL: pol_o <= bus_wdata[NCH-1:0];
                        CTRL_SEL: sel_o <= bus_wdata[NCH-1:0];
                        default:  cfg_o <= bus_wdata[NCH-1:0];
                    endcase
                end
                GRP_PER:  per_buf_o[idx]  <= bus_wdata;
                GRP_DUTY: duty_buf_o[idx] <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Counter write pulses, one per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_cwr
        assign cnt_wr_o[g] = bus_wr && (grp == GRP_CNT) && (idx == 2'(g));
    end

    // Read mux over all register groups.
    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_CTRL: begin
                case (idx)
                    CTRL_EN:  bus_rdata[NCH-1:0] = en_o;
                    CTRL_POL: bus_rdata[NCH-1:0] = pol_o;
                    CTRL_SEL: bus_rdata[NCH-1:0] = sel_o;
                    default:  bus_rdata[NCH-1:0] = cfg_o;
                endcase
            end
            GRP_CNT:  bus_rdata = cnt_in[idx];
            GRP_PER:  bus_rdata = per_buf_o[idx];
            default:  bus_rdata = duty_buf_o[idx];
        endcase
    end
endmodule

// File: rtl/pwm_quad_step.sv
`timescale 1ns/1ps
// Counter step: next count, wrap flag and duty-compare for a W-bit channel.
// Pure combinational; assumes the count never exceeds the period.
module pwm_quad_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    output logic [W-1:0] nxt,
    output logic         wrap,
    output logic         act
);
    assign wrap = (cnt == per);
    assign nxt  = wrap ? '0 : cnt + W'(1);
    assign act  = (cnt < duty);
endmodule

// File: rtl/pwm_quad_pair.sv
`timescale 1ns/1ps
// Channel pair: two CW-bit channels that can run alone or as one 2*CW channel.
// Holds counters, active period/duty and the registered pins.
// Assumes the even channel (index 0) is the low byte and owns joined-mode controls.
module pwm_quad_pair #(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           tick,
    input  logic [1:0]           en,
    input  logic [1:0]           pol,
    input  logic                 jn,
    input  logic [1:0][CW-1:0]   per_buf,
    input  logic [1:0][CW-1:0]   duty_buf,
    input  logic [1:0]           cnt_wr,
    output logic [1:0][CW-1:0]   cnt_o,
    output logic [1:0][CW-1:0]   per_o,
    output logic [1:0]           pwm_o
);
    localparam int DW = 2 * CW;

    logic [1:0][CW-1:0] cnt_q, per_q, duty_q;
    logic               jn_q;
    logic               restart;

    logic [CW-1:0] nxt8 [2];
    logic [1:0]    wrap8, act8;
    logic [DW-1:0] cnt_w, per_w, duty_w, nxt16;
    logic          wrap16, act16;

    assign cnt_w   = cnt_q;
    assign per_w   = per_q;
    assign duty_w  = duty_q;
    assign restart = (jn != jn_q);

    for (genvar g = 0; g < 2; g++) begin : g_s8
        pwm_quad_step #(.W(CW)) u_step8 (
            .cnt (cnt_q[g]),
            .per (per_q[g]),
            .duty(duty_q[g]),
            .nxt (nxt8[g]),
            .wrap(wrap8[g]),
            .act (act8[g])
        );
    end

    pwm_quad_step #(.W(DW)) u_step16 (
        .cnt (cnt_w),
        .per (per_w),
        .duty(duty_w),
        .nxt (nxt16),
        .wrap(wrap16),
        .act (act16)
    );

    // Counter and active-register update in joined or split mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
            jn_q   <= 1'b0;
        end else begin
            jn_q <= jn;
            if (jn) begin
                if (!en[0] || restart || (|cnt_wr)) begin
                    cnt_q  <= '0;
                    per_q  <= per_buf;
                    duty_q <= duty_buf;
                end else if (tick[0]) begin
                    cnt_q <= nxt16;
                    if (wrap16) begin
                        per_q  <= per_buf;
                        duty_q <= duty_buf;
                    end
                end
            end else begin
                for (int i = 0; i < 2; i++) begin
                    if (!en[i] || restart || cnt_wr[i]) begin
                        cnt_q[i]  <= '0;
                        per_q[i]  <= per_buf[i];
                        duty_q[i] <= duty_buf[i];
                    end else if (tick[i]) begin
                        cnt_q[i] <= nxt8[i];
                        if (wrap8[i]) begin
                            per_q[i]  <= per_buf[i];
                            duty_q[i] <= duty_buf[i];
                        end
                    end
                end
            end
        end
    end

    // Registered pin levels from the compare results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_o <= '0;
        end else if (jn) begin
            pwm_o[0] <= en[0] & (act16 ? pol[0] : ~pol[0]);
            pwm_o[1] <= 1'b0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                pwm_o[i] <= en[i] & (act8[i] ? pol[i] : ~pol[i]);
            end
        end
    end

    assign cnt_o = cnt_q;
    assign per_o = per_q;
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
// Quad PWM top: register file, per-channel strobe routing and two channel pairs.
// Assumes the three strobes are single-cycle clock enables in the clk domain.
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    input  logic           stb_a,
    input  logic           stb_b,
    input  logic           stb_s,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]          en_w, pol_w, sel_w, cfg_w, cnt_wr_w;
    logic [NCH-1:0][CW-1:0]  per_buf_w, duty_buf_w;
    wire  [NCH-1:0][CW-1:0]  cnt_w, per_w;
    wire  [NCH-1:0]          pwm_w;
    wire  [NCH-1:0]          tick_w;

    pwm_quad_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_in    (cnt_w),
        .en_o      (en_w),
        .pol_o     (pol_w),
        .sel_o     (sel_w),
        .cfg_o     (cfg_w),
        .per_buf_o (per_buf_w),
        .duty_buf_o(duty_buf_w),
        .cnt_wr_o  (cnt_wr_w)
    );

    // Strobe routing: A, or the pair's alternate (B or S).
    for (genvar c = 0; c < NCH; c++) begin : g_tick
        assign tick_w[c] = sel_w[c] ? (cfg_w[NPAIR + c/2] ? stb_s : stb_b) : stb_a;
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_quad_pair #(.CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_w[2*p+1:2*p]),
            .en      (en_w[2*p+1:2*p]),
            .pol     (pol_w[2*p+1:2*p]),
            .jn      (cfg_w[p]),
            .per_buf (per_buf_w[2*p+1:2*p]),
            .duty_buf(duty_buf_w[2*p+1:2*p]),
            .cnt_wr  (cnt_wr_w[2*p+1:2*p]),
            .cnt_o   (cnt_w[2*p+1:2*p]),
            .per_o   (per_w[2*p+1:2*p]),
            .pwm_o   (pwm_w[2*p+1:2*p])
        );
    end

    assign pwm_out = pwm_w;
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
// Checker: cycle-level properties of the quad PWM, bound to the top module.
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int CW = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [AW-1:0]           bus_addr,
    input logic [NCH-1:0]          en,
    input logic [NCH-1:0]          cfg,
    input logic [NCH-1:0]          pwm,
    input logic [NCH-1:0][CW-1:0]  cnt,
    input logic [NCH-1:0][CW-1:0]  per
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [AW-1:0] CADDR = AW'(4 + c);

        // R5
        dis_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en[c]) |-> !pwm[c]);

        // R7
        cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_wr && (bus_addr == CADDR)) |-> (cnt[c] == '0));
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pr
        // R9
        odd_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg[p]) |-> !pwm[2*p+1]);

        // R3
        wide_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p] && $past(cfg[p])) |-> ({cnt[2*p+1], cnt[2*p]} <= {per[2*p+1], per[2*p]}));

        // R3
        lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg[p] && !$past(cfg[p])) |-> (cnt[2*p] <= per[2*p]));

        // R3
        hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg[p] && !$past(cfg[p])) |-> (cnt[2*p+1] <= per[2*p+1]));
    end
endmodule

bind pwm_quad pwm_quad_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .en      (en_w),
    .cfg     (cfg_w),
    .pwm     (pwm_out),
    .cnt     (cnt_w),
    .per     (per_w)
);

// File: tb/pwm_quad_bench.sv
`timescale 1ns/1ps
// Bench for pwm_quad: a table of waveform vectors, then directed scenarios.
module pwm_quad_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    wire  [7:0] bus_rdata;
    logic       stb_a = 1'b0, stb_b = 1'b0, stb_s = 1'b0;
    wire  [3:0] pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_quad u_pwm_quad (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stb_a(stb_a), .stb_b(stb_b), .stb_s(stb_s), .pwm_out(pwm_out)
    );

    // {polarity, period, duty, expected high cycles per period} for channel 0
    localparam logic [31:0] VEC [7] = '{
        {8'd1, 8'd9, 8'd3, 8'd3},
        {8'd0, 8'd9, 8'd3, 8'd7},
        {8'd1, 8'd4, 8'd0, 8'd0},
        {8'd0, 8'd4, 8'd0, 8'd5},
        {8'd1, 8'd4, 8'd4, 8'd4},
        {8'd1, 8'd4, 8'd7, 8'd5},
        {8'd0, 8'd7, 8'd9, 8'd0}
    };

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    // which: 0 = A, 1 = B, 2 = S
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0: stb_a = 1'b1;
                1: stb_b = 1'b1;
                default: stb_s = 1'b1;
            endcase
        end
        @(negedge clk);
        stb_a = 1'b0; stb_b = 1'b0; stb_s = 1'b0;
    endtask

    initial begin
        int d, hi, hi1;
        repeat (3) @(negedge clk);
        chk("R1 pins in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 0);
        end

        // R2 register map
        wr(4'd1, 8'hFF); rd(4'd1, d); chk("R2 polarity keeps 4 bits", d, 8'h0F);
        wr(4'd1, 8'h00);
        wr(4'hB, 8'h5A); rd(4'hB, d); chk("R2 period ch3 readback", d, 8'h5A);
        wr(4'hF, 8'hC3); rd(4'hF, d); chk("R2 duty ch3 readback", d, 8'hC3);
        wr(4'd3, 8'h05); rd(4'd3, d); chk("R2 pair config readback", d, 8'h05);
        wr(4'd3, 8'h00);

        // R4 waveform table, channel 0 on strobe A every cycle
        @(negedge clk); stb_a = 1'b1;
        wr(4'd0, 8'h01);
        for (int v = 0; v < 7; v++) begin
            wr(4'd1, VEC[v][31:24]);
            wr(4'd8, VEC[v][23:16]);
            wr(4'd12, VEC[v][15:8]);
            wr(4'd4, 8'h00);
            repeat (3) @(negedge clk);
            hi = 0;
            for (int k = 0; k < int'(VEC[v][23:16]) + 1; k++) begin
                @(negedge clk);
                if (pwm_out[0]) hi++;
            end
            chk($sformatf("R4 vector %0d high time", v), hi, int'(VEC[v][7:0]));
        end

        // R5 channel 1 is disabled while sharing strobe A
        chk("R5 disabled pin 1 low", int'(pwm_out[1]), 0);
        rd(4'd5, d); chk("R5 disabled counter 1 at zero", d, 0);

        // R6 held reload, stepped by single ticks
        @(negedge clk); stb_a = 1'b0;
        wr(4'd1, 8'h01); wr(4'd8, 8'd9); wr(4'd12, 8'd3); wr(4'd4, 8'h00);
        wr(4'd12, 8'd6);
        pulse(0, 5);
        repeat (2) @(negedge clk);
        chk("R6 old duty still active", int'(pwm_out[0]), 0);
        rd(4'd4, d); chk("R3 counter after 5 ticks", d, 5);
        pulse(0, 10);
        repeat (2) @(negedge clk);
        chk("R6 new duty after wrap", int'(pwm_out[0]), 1);
        rd(4'd4, d); chk("R3 counter after wrap", d, 5);

        // R7 forced reload by counter write
        wr(4'd12, 8'd2); wr(4'd4, 8'h00);
        rd(4'd4, d); chk("R7 counter cleared", d, 0);
        pulse(0, 5);
        repeat (2) @(negedge clk);
        chk("R7 forced duty active", int'(pwm_out[0]), 0);

        // R5 disabling a running channel
        wr(4'd0, 8'h00);
        repeat (2) @(negedge clk);
        chk("R5 pin 0 low when disabled", int'(pwm_out[0]), 0);
        rd(4'd4, d); chk("R5 counter 0 cleared when disabled", d, 0);

        // R8 strobe routing on channel 2
        wr(4'd0, 8'h04); wr(4'd2, 8'h04); wr(4'd3, 8'h08);
        wr(4'hA, 8'd200); wr(4'd6, 8'h00);
        pulse(1, 3); rd(4'd6, d); chk("R8 B ignored when S chosen", d, 0);
        pulse(2, 4); rd(4'd6, d); chk("R8 S advances", d, 4);
        pulse(0, 2); rd(4'd6, d); chk("R8 A ignored when select=1", d, 4);
        wr(4'd3, 8'h00);
        pulse(1, 2); rd(4'd6, d); chk("R8 B advances", d, 6);

        // R9 joined pair 0: period 300, duty 100, polarity high
        wr(4'd0, 8'h01); wr(4'd2, 8'h00); wr(4'd1, 8'h01); wr(4'd3, 8'h01);
        wr(4'd8, 8'h2C); wr(4'd9, 8'h01); wr(4'd12, 8'd100); wr(4'd13, 8'h00);
        wr(4'd4, 8'h00);
        @(negedge clk); stb_a = 1'b1;
        repeat (3) @(negedge clk);
        hi = 0; hi1 = 0;
        for (int k = 0; k < 301; k++) begin
            @(negedge clk);
            if (pwm_out[0]) hi++;
            if (pwm_out[1]) hi1++;
        end
        chk("R9 16-bit high time", hi, 100);
        chk("R9 odd pin held low", hi1, 0);
        @(negedge clk); stb_a = 1'b0;
        wr(4'd5, 8'h00);
        rd(4'd4, d); chk("R9 odd counter write clears low byte", d, 0);
        pulse(0, 260);
        rd(4'd5, d); chk("R9 high byte after carry", d, 1);
        rd(4'd4, d); chk("R9 low byte after carry", d, 4);

        // R10 splitting the pair clears it
        wr(4'd3, 8'h00);
        rd(4'd4, d); chk("R10 low counter cleared on split", d, 0);
        rd(4'd5, d); chk("R10 high counter cleared on split", d, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule